// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block decides when a memory-and-logic subsystem may drop into a low-power state. It watches an address-strobe line that the processor pulses on every bus cycle. Once the strobe has stopped moving for a fixed number of input-clock periods, the block raises a registered power-down flag. It also drives a set of control outputs from that flag. These outputs isolate the processor bus from the memories and logic, send the memories into standby, float the peripheral I/O, and gate a software-chosen subset of logic-array inputs.

Three separate causes end power-down: a new edge on the strobe, the active-low chip-select being sampled low, or the synchronous reset. The automatic function and the input-gating choices sit in two small control registers that are written through a simple write-only register port. Gating bit 0 stops the shared clock from reaching the logic array. The idle timer itself always runs from the ungated clock.

Top module: `apd_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pdn`, `bus_block`, `mem_standby`, `periph_hiz` and `gate_mask` are all 0, and the automatic function is disabled.
- R2: A write with `reg_addr`=0 stores the enable in data bit 1 and gate selects in data bits 5:4. A write with `reg_addr`=2 stores gate selects in data bits 6:2. All other addresses and all other data bits are ignored.
- R3: The idle count advances by one on every clock edge at which the function is enabled, `cs_n` is high and no strobe edge is detected. The edge that writes the enable bit counts as such an edge. `pdn` rises on the edge after the count has reached 15, so after an enabling write at edge e, `pdn` is first high after edge e+15.
- R4: The count saturates at 15, and `pdn` stays high for as long as no wake cause is present.
- R5: A rising or a falling change on `strobe`, set up before edge k, passes a two-flop synchroniser and is detected at edge k+2. That edge clears `pdn` and the count, so with no further activity `pdn` rises again at edge k+18.
- R6: `pdn` falls at the first edge where `cs_n` is sampled low, and the count is held at zero while `cs_n` stays low. If `cs_n` is first sampled high again at edge m, `pdn` rises at edge m+15.
- R7: Asserting `rst` while powered down clears `pdn` at the next edge and also clears the enable bit, so power-down does not return after `rst` is released.
- R8: A write that clears the enable bit drops `pdn` at that same write edge and holds the count at zero while the bit stays clear.
- R9: `bus_block`, `mem_standby` and `periph_hiz` always equal `pdn`.
- R10: While `pdn` is high, `gate_mask[1:0]` equals register 0 bits 5:4 and `gate_mask[6:2]` equals register 2 bits 6:2. While `pdn` is low, `gate_mask` is zero. `gate_mask[0]` gates the shared clock into the logic array and has no effect on the idle count.
- R11: Strobe edges that arrive more often than every 15 cycles keep `pdn` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; drives the idle timer, never gated |
| rst | input | 1 | Synchronous active-high reset; also a wake cause |
| strobe | input | 1 | Asynchronous address strobe from the processor |
| cs_n | input | 1 | Active-low chip-select, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| pdn | output | 1 | Power-down flag, registered |
| bus_block | output | 1 | Blocks the processor bus from memories and logic |
| mem_standby | output | 1 | Sends all memories into standby |
| periph_hiz | output | 1 | Floats the peripheral I/O |
| gate_mask | output | 7 | Per-input gating of logic-array inputs; bit 0 is the shared clock |

## Verification
A count stuck or wrapping inside the block shows at `pdn` as an entry one or more cycles early or late. The bench pins this to the exact edge: e+15 after enabling, k+18 after a strobe change, and m+15 after chip-select is released. A missed wake shows as `pdn` still high two edges after a strobe change, or one edge after `cs_n` falls. A bad gate-select register shows as a wrong bit in `gate_mask` on the first cycle of power-down. Because `gate_mask` must be zero outside power-down, a stale select also shows at once as a nonzero mask while awake.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam int GATE_W    = 7;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] GATE_ADDR = 2'd2;
  localparam int EN_BIT    = 1;
  localparam int CTRL_G_LO = 4;
  localparam int CTRL_G_N  = 2;
  localparam int GATE_G_LO = 2;
  localparam int GATE_G_N  = 5;

  typedef struct packed {
    logic                en;
    logic [CTRL_G_N-1:0] gsel;
  } ctrl_reg_t;
endpackage

// File: rtl/apd_edge_sync.sv
module apd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_det
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign edge_det = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/apd_regs.sv
module apd_regs
  import apd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              en_nxt,
  output logic [GATE_W-1:0] sel
);
  ctrl_reg_t            ctrl_q;
  logic [GATE_G_N-1:0]  gate_q;
  logic                 ctrl_hit;
  logic                 gate_hit;
  logic                 unused_bits;

  assign ctrl_hit = we && (addr == CTRL_ADDR);
  assign gate_hit = we && (addr == GATE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      gate_q <= '0;
    end else begin
      if (ctrl_hit) begin
        ctrl_q.en   <= wdata[EN_BIT];
        ctrl_q.gsel <= wdata[CTRL_G_LO +: CTRL_G_N];
      end
      if (gate_hit) gate_q <= wdata[GATE_G_LO +: GATE_G_N];
    end
  end

  assign en_q        = ctrl_q.en;
  assign en_nxt      = ctrl_hit ? wdata[EN_BIT] : ctrl_q.en;
  assign sel         = {gate_q, ctrl_q.gsel};
  assign unused_bits = ^{wdata[DATA_W-1], wdata[3:2], wdata[0]};
endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
  parameter int IDLE_LIMIT = 15,
  parameter int N_COPIES   = 4,
  localparam int CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_nxt,
  input  logic                wake,
  output logic [CNT_W-1:0]    cnt,
  output logic [N_COPIES-1:0] pdn_q
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

  logic at_limit;
  logic pdn_nxt;

  assign at_limit = (cnt == LIMIT);
  assign pdn_nxt  = en_nxt && !wake && (pdn_q[0] || at_limit);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (!en_nxt || wake) cnt <= '0;
    else if (!at_limit)      cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < N_COPIES; i++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) pdn_q[i] <= 1'b0;
      else     pdn_q[i] <= pdn_nxt;
    end
  end
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
#(
  parameter int IDLE_LIMIT  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              cs_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              pdn,
  output logic              bus_block,
  output logic              mem_standby,
  output logic              periph_hiz,
  output logic [GATE_W-1:0] gate_mask
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);

  logic              edge_det;
  logic              en_q;
  logic              en_nxt;
  logic [GATE_W-1:0] sel;
  logic              wake;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        pdn_q;

  apd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(strobe), .edge_det(edge_det)
  );

  apd_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .en_nxt(en_nxt), .sel(sel)
  );

  assign wake = edge_det || !cs_n;

  apd_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT), .N_COPIES(4)) u_timer (
    .clk(clk), .rst(rst), .en_nxt(en_nxt), .wake(wake),
    .cnt(cnt), .pdn_q(pdn_q)
  );

  assign pdn         = pdn_q[0];
  assign bus_block   = pdn_q[1];
  assign mem_standby = pdn_q[2];
  assign periph_hiz  = pdn_q[3];
  assign gate_mask   = pdn_q[0] ? sel : '0;
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int IDLE_LIMIT = 15,
  localparam int CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             reg_we,
  input logic             pdn,
  input logic             bus_block,
  input logic             mem_standby,
  input logic             periph_hiz,
  input logic [6:0]       gate_mask,
  input logic             edge_det,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

  assert_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pdn) |-> $past(cnt) == LIMIT);

  assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == LIMIT && en_q && cs_n && !edge_det && !reg_we) |=> cnt == LIMIT);

  assert_strobe_wake_R5: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> (!pdn && cnt == '0));

  assert_cs_wake_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> !pdn);

  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (!pdn && cnt == '0));

  assert_copies_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_block == pdn) && (mem_standby == pdn) && (periph_hiz == pdn));

  assert_mask_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !pdn |-> gate_mask == '0);
endmodule

bind apd_ctrl apd_ctrl_chk #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .reg_we(reg_we), .pdn(pdn),
  .bus_block(bus_block), .mem_standby(mem_standby), .periph_hiz(periph_hiz),
  .gate_mask(gate_mask), .edge_det(edge_det), .en_q(en_q), .cnt(cnt)
);

// File: tb/apd_ctrl_test.sv
module apd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic       cs_n = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       pdn, bus_block, mem_standby, periph_hiz;
  logic [6:0] gate_mask;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  typedef struct {
    string      req;
    logic       p;
    logic [6:0] m;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  apd_ctrl uut (
    .clk(clk), .rst(rst), .strobe(strobe), .cs_n(cs_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pdn(pdn), .bus_block(bus_block), .mem_standby(mem_standby),
    .periph_hiz(periph_hiz), .gate_mask(gate_mask)
  );

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [9:0] act, exp;
      it  = sb.pop_front();
      act = {pdn, bus_block, mem_standby, periph_hiz, gate_mask[5:0]};
      exp = {it.p, it.p, it.p, it.p, it.m[5:0]};
      n_run++;
      if (act != exp || gate_mask[6] !== it.m[6]) begin
        n_fail++;
        $display("FAIL %s: pdn/bus/mem/hiz/mask act=%b %b exp=%b %b",
                 it.req, act, gate_mask, exp, it.m);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic p, input logic [6:0] m);
    item_t it;
    it.req = req; it.p = p; it.m = m;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_out("R1 reset", 1'b0, 7'h00);
    rst = 1'b0;
    tick(1);
    expect_out("R1 after reset", 1'b0, 7'h00);

    // R2/R3: selects, then enable; entry at e+15
    wr(2'd2, 8'h7C);
    wr(2'd0, 8'h32);
    tick(14);
    expect_out("R3 not yet at e+14", 1'b0, 7'h00);
    tick(1);
    expect_out("R3 entry at e+15 / R10 mask", 1'b1, 7'h7F);

    // R4 hold
    tick(30);
    expect_out("R4 stays down", 1'b1, 7'h7F);

    // R5 rising strobe wake at k+2, re-entry at k+18
    strobe = 1'b1;
    tick(2);
    expect_out("R5 still down at k+1", 1'b1, 7'h7F);
    tick(1);
    expect_out("R5 wake at k+2", 1'b0, 7'h00);
    tick(15);
    expect_out("R5 not yet at k+17", 1'b0, 7'h00);
    tick(1);
    expect_out("R5 re-entry at k+18", 1'b1, 7'h7F);

    // R6 chip-select wake and release
    cs_n = 1'b0;
    tick(1);
    expect_out("R6 cs wake", 1'b0, 7'h00);
    tick(20);
    expect_out("R6 held while cs low", 1'b0, 7'h00);
    cs_n = 1'b1;
    tick(15);
    expect_out("R6 not yet at m+14", 1'b0, 7'h00);
    tick(1);
    expect_out("R6 re-entry at m+15", 1'b1, 7'h7F);

    // R5 falling strobe also wakes
    strobe = 1'b0;
    tick(2);
    expect_out("R5 fall still down", 1'b1, 7'h7F);
    tick(1);
    expect_out("R5 fall wake", 1'b0, 7'h00);
    tick(15);
    expect_out("R5 fall not yet", 1'b0, 7'h00);
    tick(1);
    expect_out("R5 fall re-entry", 1'b1, 7'h7F);

    // R10/R2 mask mapping while down
    wr(2'd0, 8'h12);
    expect_out("R10 ctrl bit5 cleared", 1'b1, 7'h7D);
    wr(2'd2, 8'h83);
    expect_out("R2 ignored gate bits", 1'b1, 7'h01);
    wr(2'd1, 8'h00);
    tick(2);
    expect_out("R2 ignored address", 1'b1, 7'h01);
    wr(2'd3, 8'h00);
    expect_out("R2 ignored address 3", 1'b1, 7'h01);

    // R8 disable at write edge
    wr(2'd0, 8'h30);
    expect_out("R8 disable immediate", 1'b0, 7'h00);
    tick(40);
    expect_out("R8 stays up", 1'b0, 7'h00);

    // R7 reset while down
    wr(2'd0, 8'h32);
    tick(15);
    expect_out("R7 pre-reset entry", 1'b1, 7'h03);
    rst = 1'b1;
    tick(1);
    expect_out("R7 reset wakes", 1'b0, 7'h00);
    rst = 1'b0;
    tick(40);
    expect_out("R7 enable cleared", 1'b0, 7'h00);

    // R11 frequent strobe activity
    wr(2'd0, 8'h02);
    for (int i = 0; i < 6; i++) begin
      strobe = ~strobe;
      tick(10);
      expect_out("R11 busy strobe", 1'b0, 7'h00);
    end
    tick(20);
    expect_out("R11 idle after activity", 1'b1, 7'h00);

    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule